// File: doc/BRIEF.md
# Low-Voltage Reset Filter Controller

This block is the digital half of a supply-voltage supervisor. An analog comparator pair reports two things: whether the supply is at or below the falling trip level, and whether it has recovered above the higher rising trip level. The block brings both indications into the clock domain through a synchroniser. It drives a status flag that mirrors the falling comparator. When the low condition lasts long enough, it raises a reset request to the system and pulls an active-low external reset pin.

A burst of low readings shorter than the qualification window is filtered out. Once a reset has begun, it is held until the rising comparator reports recovery. Three active-high configuration inputs enable monitoring, enable reset generation, and keep the block operating while the chip is in stop mode. A one-cycle pulse marks the start of each low-voltage reset so that system logic can record the reset cause. A simple read port returns the flag in a fixed bit of a data word.

Top module: `lvr_filter_ctrl`

## Requirements
- R1: After rst_ni is released, all outputs are inactive and rst_pin_no is 1. Monitoring runs from the first clock with no action other than the enable inputs.
- R2: low_flag_o equals cmp_low_i as sampled two rising edges earlier (1 = supply at or below the trip level) whenever monitoring is active.
- R3: While cfg_mon_en_i is 0, low_flag_o is 0. The qualification count and any held reset clear at the next edge.
- R4: While cfg_rst_en_i is 0, low_flag_o still responds but no reset is requested. Dropping it while a reset is held releases the reset at the next edge.
- R5: rst_req_o rises at the edge that ends the ninth consecutive cycle with low_flag_o high. Any cycle with low_flag_o low restarts the count.
- R6: Once asserted, rst_req_o stays high until cmp_rise_i, after its two-stage synchroniser, is seen high. It then falls on the third rising edge after cmp_rise_i is applied.
- R7: rst_pin_no is 0 exactly while rst_req_o is 1.
- R8: With stop_mode_i high and cfg_stop_en_i low, monitoring is suspended: the flag is 0, the count clears and a held reset releases. With cfg_stop_en_i high, operation during stop is unchanged.
- R9: rst_cause_o is high for exactly one cycle, the first cycle in which rst_req_o is high.
- R10: When rd_en_i is 1, rd_data_o carries low_flag_o in bit 3 and zeros elsewhere. When rd_en_i is 0, rd_data_o is all zero.
- R11: An arbitrarily long low run keeps the reset asserted. The count saturates and never wraps, so no second cause pulse appears.
- R12: If the rising indication and a qualified low fall in the same cycle while a reset is held, the release wins. If the low persists, a new reset, with a new cause pulse, starts at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_low_i | input | 1 | Asynchronous comparator: supply at or below falling trip |
| cmp_rise_i | input | 1 | Asynchronous comparator: supply above rising trip |
| cfg_mon_en_i | input | 1 | Monitoring enable |
| cfg_rst_en_i | input | 1 | Reset generation enable |
| cfg_stop_en_i | input | 1 | Keep operating in stop mode |
| stop_mode_i | input | 1 | Chip is in stop mode |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | 8 | Status read data, flag in bit 3 |
| low_flag_o | output | 1 | Low-supply status flag |
| rst_req_o | output | 1 | Reset request to the system |
| rst_pin_no | output | 1 | External reset pin drive, active low |
| rst_cause_o | output | 1 | One-cycle pulse at the start of a low-voltage reset |

## Verification
Release and re-qualification can land in the same cycle. This happens when the rising indication arrives while the falling indication is still asserted and the saturated count still qualifies a trip. The bench provokes it by raising cmp_rise_i and keeping cmp_low_i high during a held reset. It then judges cycle by cycle against its reference model, which expects one cycle of release followed by a fresh reset and a second cause pulse. A second collision, a configuration enable dropping on the very cycle a reset qualifies, is provoked by toggling cfg_rst_en_i and cfg_mon_en_i during long low runs.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } hold_st_e;

  typedef struct packed {
    logic mon_en;
    logic rst_en;
    logic stop_en;
  } lvr_cfg_t;

  localparam int unsigned IDX_LOW  = 0;
  localparam int unsigned IDX_RISE = 1;
  localparam int unsigned N_CMP    = 2;

endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lvr_qual_cnt.sv
module lvr_qual_cnt #(
  parameter int unsigned QUAL_CYCLES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic low_i,
  output logic qualified_o
);

  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = (cnt_q == TERM);

  // cnt_q = earlier consecutive low cycles; saturates at TERM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!enable_i || !low_i) cnt_q <= '0;
    else if (!at_term)          cnt_q <= cnt_q + 1'b1;
  end

  assign qualified_o = enable_i & low_i & at_term;

endmodule

// File: rtl/lvr_hold_fsm.sv
module lvr_hold_fsm
  import lvr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic trip_i,
  input  logic rise_i,
  output logic hold_o,
  output logic cause_o
);

  hold_st_e st_q, st_d;
  logic     cause_q, cause_d;

  always_comb begin
    st_d    = st_q;
    cause_d = 1'b0;
    if (clear_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trip_i) begin
          st_d    = ST_HOLD;
          cause_d = 1'b1;
        end
        ST_HOLD: if (rise_i) st_d = ST_IDLE;  // release wins over re-trip
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cause_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
    end
  end

  assign hold_o  = (st_q == ST_HOLD);
  assign cause_o = cause_q;

endmodule

// File: rtl/lvr_status_rd.sv
module lvr_status_rd #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic              rd_en_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rd_data_o
);

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) rd_data_o[FLAG_BIT] = flag_i;
  end

endmodule

// File: rtl/lvr_filter_ctrl.sv
module lvr_filter_ctrl
  import lvr_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 9,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FLAG_BIT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_low_i,
  input  logic              cmp_rise_i,
  input  logic              cfg_mon_en_i,
  input  logic              cfg_rst_en_i,
  input  logic              cfg_stop_en_i,
  input  logic              stop_mode_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              low_flag_o,
  output logic              rst_req_o,
  output logic              rst_pin_no,
  output logic              rst_cause_o
);

  lvr_cfg_t         cfg;
  logic [N_CMP-1:0] cmp_raw, cmp_s;
  logic             low_s, rise_s;
  logic             active, trip, clear, hold;

  assign cfg = '{mon_en: cfg_mon_en_i, rst_en: cfg_rst_en_i, stop_en: cfg_stop_en_i};

  assign cmp_raw[IDX_LOW]  = cmp_low_i;
  assign cmp_raw[IDX_RISE] = cmp_rise_i;

  lvr_sync #(
    .WIDTH (N_CMP),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw),
    .q_o   (cmp_s)
  );

  assign low_s  = cmp_s[IDX_LOW];
  assign rise_s = cmp_s[IDX_RISE];

  // stop suspends the monitor unless explicitly kept alive
  assign active = cfg.mon_en & (~stop_mode_i | cfg.stop_en);

  lvr_qual_cnt #(
    .QUAL_CYCLES(QUAL_CYCLES)
  ) i_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (active),
    .low_i      (low_s),
    .qualified_o(trip)
  );

  assign clear = ~active | ~cfg.rst_en;

  lvr_hold_fsm i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .trip_i (trip),
    .rise_i (rise_s),
    .hold_o (hold),
    .cause_o(rst_cause_o)
  );

  assign low_flag_o = active & low_s;
  assign rst_req_o  = hold;
  assign rst_pin_no = ~hold;

  lvr_status_rd #(
    .DATA_W  (DATA_W),
    .FLAG_BIT(FLAG_BIT)
  ) i_rd (
    .rd_en_i  (rd_en_i),
    .flag_i   (low_flag_o),
    .rd_data_o(rd_data_o)
  );

endmodule

// File: rtl/lvr_filter_ctrl_chk.sv
module lvr_filter_ctrl_chk #(
  parameter int unsigned QUAL_CYCLES = 9,
  parameter int unsigned DATA_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_mon_en_i,
  input logic              cfg_rst_en_i,
  input logic              cfg_stop_en_i,
  input logic              stop_mode_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              low_flag_o,
  input logic              rst_req_o,
  input logic              rst_pin_no,
  input logic              rst_cause_o
);

  // consecutive flag-high cycles, saturating
  logic [7:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!low_flag_o) run_q <= '0;
    else if (run_q != 8'hff) run_q <= run_q + 1'b1;
  end

  a_r3_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mon_en_i |-> !low_flag_o);

  a_r3_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mon_en_i |=> !rst_req_o);

  a_r4_no_rst_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rst_en_i |=> !rst_req_o);

  a_r5_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> (run_q >= 8'(QUAL_CYCLES)));

  a_r7_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !rst_pin_no);

  a_r8_stop_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mode_i && !cfg_stop_en_i) |-> !low_flag_o);

  a_r9_cause_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cause_o |-> $rose(rst_req_o));

  a_r9_cause_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cause_o |=> !rst_cause_o);

  a_r10_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));

endmodule

bind lvr_filter_ctrl lvr_filter_ctrl_chk #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .DATA_W     (DATA_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_mon_en_i (cfg_mon_en_i),
  .cfg_rst_en_i (cfg_rst_en_i),
  .cfg_stop_en_i(cfg_stop_en_i),
  .stop_mode_i  (stop_mode_i),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .low_flag_o   (low_flag_o),
  .rst_req_o    (rst_req_o),
  .rst_pin_no   (rst_pin_no),
  .rst_cause_o  (rst_cause_o)
);

// File: tb/test_lvr_filter_ctrl.sv
`timescale 1ns/1ps
module test_lvr_filter_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       low = 1'b0, rise = 1'b1;
  logic       mon = 1'b1, ren = 1'b1, sen = 1'b0, stp = 1'b0, rd = 1'b1;
  logic [7:0] rd_data;
  logic       flag, req, pin_n, cause;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  lvr_filter_ctrl i_lvr_filter_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmp_low_i    (low),
    .cmp_rise_i   (rise),
    .cfg_mon_en_i (mon),
    .cfg_rst_en_i (ren),
    .cfg_stop_en_i(sen),
    .stop_mode_i  (stp),
    .rd_en_i      (rd),
    .rd_data_o    (rd_data),
    .low_flag_o   (flag),
    .rst_req_o    (req),
    .rst_pin_no   (pin_n),
    .rst_cause_o  (cause)
  );

  // behavioural reference
  bit sq_low[$];
  bit sq_rise[$];
  int run_m = 0;
  bit hold_m = 0, cause_m = 0;

  function automatic bit m_active();
    return mon && (!stp || sen);
  endfunction

  initial begin
    sq_low  = '{0, 0};
    sq_rise = '{0, 0};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_low  = '{0, 0};
      sq_rise = '{0, 0};
      run_m   = 0;
      hold_m  = 0;
      cause_m = 0;
    end else begin
      bit ls, rs, act, trip, nh, nc;
      ls   = sq_low[0];
      rs   = sq_rise[0];
      act  = m_active();
      trip = act && ren && ls && (run_m >= 8);  // ninth low cycle
      nc   = 0;
      if (!act || !ren)  nh = 0;
      else if (hold_m)   nh = !rs;
      else begin
        nh = trip;
        nc = trip;
      end
      run_m   = (act && ls) ? run_m + 1 : 0;
      hold_m  = nh;
      cause_m = nc;
      void'(sq_low.pop_front());
      sq_low.push_back(low);
      void'(sq_rise.pop_front());
      sq_rise.push_back(rise);
    end
  end

  task automatic chk1(string tag, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s t=%0t actual=%0h expected=%0h", tag, nm, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit f;
    f = m_active() && sq_low[0];
    chk1("R2", "low_flag_o", flag, f);
    chk1("R5", "rst_req_o", req, hold_m);
    chk1("R7", "rst_pin_no", pin_n, !hold_m);
    chk1("R9", "rst_cause_o", cause, cause_m);
    chk1("R10", "rd_data_o", rd_data, rd ? (8'(f) << 3) : 8'h00);
  endtask

  // drive comparator inputs for n cycles, comparing each cycle
  task automatic run(bit l, bit r, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      low  = l;
      rise = r;
      #1 compare_all();
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 compare_all();            // R1 reset state
    rst_n = 1'b1;
    run(0, 1, 4);                // R1 idle after reset
    run(1, 0, 1); run(0, 1, 1);  // R2 flag follows comparator
    run(1, 0, 2); run(0, 1, 3);
    run(1, 0, 8); run(0, 1, 1);  // R5 eight-cycle run filtered
    run(1, 0, 12);               // R5 qualifies at ninth cycle
    run(0, 0, 5);                // R6 held between thresholds
    run(0, 1, 5);                // R6 release on rise
    run(1, 0, 12);               // R12 setup
    run(1, 1, 6);                // R12 release then re-trip
    run(0, 1, 5);
    run(1, 0, 40);               // R11 long run, no second pulse
    run(0, 1, 5);
    ren = 1'b0;                  // R4 flag only
    run(1, 0, 15);
    ren = 1'b1; run(1, 0, 3);    // R4 re-enable while low
    ren = 1'b0; run(1, 0, 2);    // R4 drop releases
    ren = 1'b1; run(0, 1, 5);
    run(1, 0, 12);               // R3 disable mid-hold
    mon = 1'b0; run(1, 0, 5);
    mon = 1'b1; run(0, 1, 5);
    stp = 1'b1;                  // R8 stop suspends
    run(1, 0, 15);
    sen = 1'b1; run(1, 0, 12);   // R8 stop kept alive
    stp = 1'b0; sen = 1'b0;
    rd = 1'b0; run(1, 0, 3);     // R10 read disabled
    rd = 1'b1; run(1, 0, 2);
    run(0, 1, 6);
    summary();
  end

endmodule